// File: doc/BRIEF.md
# CPU Cycle Phase Generator

This block turns a reference clock into processor cycles. It produces the two internal non-overlapping phase clocks, a stretched external bus strobe (`m2`) and two single-tick enables that mark where each cycle starts and where its second half starts. A bus sequencer uses the enables to launch addresses and to capture read data.

The strobe edges fall on half master-clock boundaries. For that reason the block is clocked by `clk_2x`, which runs at twice the master rate, so one tick is half a master clock. In the slower-video region (`region_pal` = 0) a processor cycle is 12 master clocks, which is 24 ticks. In the other region (`region_pal` = 1) it is 16 master clocks, which is 32 ticks.

`phi2` is high for exactly the second half of every cycle. `m2` rises earlier than `phi2` to widen the window in which slow memories can answer. `m2` falls together with `phi2`, and that falling edge is the start of the next cycle.

Top module: `cpu_phase_gen`

## Requirements
- R1: While `rst` is sampled high on a `clk_2x` edge, the outputs after that edge are `m2`=0, `phi2`=0, `phi1`=1, `cycle_start`=0 and `phi2_start`=0. The tick after the last reset edge is tick 1 of a new cycle. The first `cycle_start` then appears one full period (24 or 32 ticks) after the last reset edge, and the region in force is the `region_pal` value sampled during reset.
- R2: With `region_pal`=0 sampled, `cycle_start` pulses occur every 24 ticks (12 master clocks).
- R3: With `region_pal`=1 sampled, `cycle_start` pulses occur every 32 ticks (16 master clocks).
- R4: `phi2` is high for exactly half of each cycle: 12 ticks in region 0 and 16 ticks in region 1. `phi1` is always the complement of `phi2`.
- R5: In region 0, `m2` rises 9 ticks after the cycle start and stays high for 15 ticks (7.5 master clocks, a 5/8 duty).
- R6: In region 1, `m2` rises 13 ticks after the cycle start and stays high for 19 ticks (9.5 master clocks, a 19/32 duty).
- R7: `m2` rises before `phi2`. Both fall on the same edge, and `cycle_start` is high for exactly that one tick.
- R8: `phi2_start` is a one-tick pulse in the tick where `phi2` rises. It is never high together with `cycle_start`.
- R9: `region_pal` is sampled only on the edge that ends a cycle. A change in the middle of a cycle, or a pulse that is withdrawn before the cycle ends, leaves the current cycle length unchanged. A value present on the final tick governs the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Reference clock at twice the master rate; one tick = half master clock |
| rst | input | 1 | Synchronous reset, active high |
| region_pal | input | 1 | Region select: 0 = 24-tick cycle, 1 = 32-tick cycle |
| phi1 | output | 1 | Internal phase 1, high in the first half of the cycle |
| phi2 | output | 1 | Internal phase 2, high in the second half of the cycle |
| m2 | output | 1 | Stretched external bus strobe |
| cycle_start | output | 1 | One-tick pulse on the tick where `m2` falls |
| phi2_start | output | 1 | One-tick pulse on the tick where `phi2` rises |

## Verification
The divider is run in steady state in both regions. Each edge of `m2` and `phi2` is timed in ticks from the cycle start, which separates a wrong period from a wrong strobe duty or a misplaced midpoint. Region changes are applied at an early mid-cycle tick, as a pulse withdrawn before the boundary, and on the final tick of a cycle. These three cases separate sampling at the boundary from sampling at every tick. Reset is applied from idle and in the middle of a cycle, in each region, to show the restart point and the region picked up during reset.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef enum logic {
        REGION_SHORT = 1'b0,
        REGION_LONG  = 1'b1
    } region_e;

endpackage

// File: rtl/cpg_counter.sv
module cpg_counter
    import cpg_pkg::*;
#(
    parameter int SHORT_TICKS = 24,
    parameter int LONG_TICKS  = 32,
    parameter int CW          = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          region_pal,
    output logic [CW-1:0] cnt_next,
    output region_e       mode_next
);

    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        region_e       mode;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        logic [CW-1:0] last;
        logic          wrap;
        ctr_d = ctr_q;
        last  = (ctr_q.mode == REGION_LONG) ? LONG_LAST : SHORT_LAST;
        wrap  = (ctr_q.cnt == last);
        if (wrap) begin
            ctr_d.cnt  = '0;
            ctr_d.mode = region_e'(region_pal);
        end else begin
            ctr_d.cnt  = ctr_q.cnt + 1'b1;
        end
        if (rst) begin
            ctr_d.cnt  = '0;
            ctr_d.mode = region_e'(region_pal);
        end
    end

    always_ff @(posedge clk) begin
        ctr_q <= ctr_d;
    end

    assign cnt_next  = ctr_d.cnt;
    assign mode_next = ctr_d.mode;

endmodule

// File: rtl/cpg_shaper.sv
module cpg_shaper
    import cpg_pkg::*;
#(
    parameter int SHORT_TICKS = 24,
    parameter int LONG_TICKS  = 32,
    parameter int SHORT_M2_HI = 15,
    parameter int LONG_M2_HI  = 19,
    parameter int CW          = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_next,
    input  region_e       mode_next,
    output logic          phi2,
    output logic          m2,
    output logic          cycle_start,
    output logic          phi2_start
);

    localparam logic [CW-1:0] SHORT_HALF = CW'(SHORT_TICKS / 2);
    localparam logic [CW-1:0] LONG_HALF  = CW'(LONG_TICKS / 2);
    localparam logic [CW-1:0] SHORT_RISE = CW'(SHORT_TICKS - SHORT_M2_HI);
    localparam logic [CW-1:0] LONG_RISE  = CW'(LONG_TICKS - LONG_M2_HI);

    typedef struct packed {
        logic phi2;
        logic m2;
        logic cyc;
        logic mid;
    } shape_t;

    shape_t shp_d, shp_q;

    always_comb begin
        logic [CW-1:0] half;
        logic [CW-1:0] rise;
        half      = (mode_next == REGION_LONG) ? LONG_HALF : SHORT_HALF;
        rise      = (mode_next == REGION_LONG) ? LONG_RISE : SHORT_RISE;
        shp_d.phi2 = (cnt_next >= half);
        shp_d.m2   = (cnt_next >= rise);
        shp_d.cyc  = (cnt_next == '0);
        shp_d.mid  = (cnt_next == half);
        if (rst) begin
            shp_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        shp_q <= shp_d;
    end

    assign phi2        = shp_q.phi2;
    assign m2          = shp_q.m2;
    assign cycle_start = shp_q.cyc;
    assign phi2_start  = shp_q.mid;

endmodule

// File: rtl/cpu_phase_gen.sv
module cpu_phase_gen
    import cpg_pkg::*;
#(
    parameter int SHORT_TICKS = 24,
    parameter int LONG_TICKS  = 32,
    parameter int SHORT_M2_HI = 15,
    parameter int LONG_M2_HI  = 19
) (
    input  logic clk_2x,
    input  logic rst,
    input  logic region_pal,
    output logic phi1,
    output logic phi2,
    output logic m2,
    output logic cycle_start,
    output logic phi2_start
);

    localparam int MAX_TICKS = (SHORT_TICKS > LONG_TICKS) ? SHORT_TICKS : LONG_TICKS;
    localparam int CW        = $clog2(MAX_TICKS);

    logic [CW-1:0] cnt_next;
    region_e       mode_next;
    logic          phi2_w;

    cpg_counter #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS),
        .CW         (CW)
    ) u_counter (
        .clk       (clk_2x),
        .rst       (rst),
        .region_pal(region_pal),
        .cnt_next  (cnt_next),
        .mode_next (mode_next)
    );

    cpg_shaper #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS),
        .SHORT_M2_HI(SHORT_M2_HI),
        .LONG_M2_HI (LONG_M2_HI),
        .CW         (CW)
    ) u_shaper (
        .clk        (clk_2x),
        .rst        (rst),
        .cnt_next   (cnt_next),
        .mode_next  (mode_next),
        .phi2       (phi2_w),
        .m2         (m2),
        .cycle_start(cycle_start),
        .phi2_start (phi2_start)
    );

    assign phi2 = phi2_w;
    assign phi1 = ~phi2_w;

endmodule

// File: rtl/cpg_checker.sv
module cpg_checker (
    input logic clk,
    input logic rst,
    input logic phi2,
    input logic m2,
    input logic cycle_start,
    input logic phi2_start
);

    assert_start_on_m2_fall_R7: assert property (@(posedge clk) disable iff (rst)
        cycle_start |-> ($fell(m2) && $fell(phi2)));

    assert_m2_fall_marks_start_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(m2) |-> cycle_start);

    assert_phi2_within_m2_R7: assert property (@(posedge clk) disable iff (rst)
        phi2 |-> m2);

    assert_phi2_fall_marks_start_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(phi2) |-> cycle_start);

    assert_mid_on_phi2_rise_R8: assert property (@(posedge clk) disable iff (rst)
        phi2_start |-> $rose(phi2));

    assert_phi2_rise_flagged_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(phi2) |-> phi2_start);

    assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cycle_start, phi2_start}));

    assert_start_single_tick_R7: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start);

endmodule

bind cpu_phase_gen cpg_checker u_chk (
    .clk        (clk_2x),
    .rst        (rst),
    .phi2       (phi2),
    .m2         (m2),
    .cycle_start(cycle_start),
    .phi2_start (phi2_start)
);

// File: tb/cpu_phase_gen_test.sv
module cpu_phase_gen_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic region_pal = 1'b0;
    logic phi1, phi2, m2, cycle_start, phi2_start;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cpu_phase_gen uut (
        .clk_2x     (clk),
        .rst        (rst),
        .region_pal (region_pal),
        .phi1       (phi1),
        .phi2       (phi2),
        .m2         (m2),
        .cycle_start(cycle_start),
        .phi2_start (phi2_start)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reset then time the first cycle; leaves the bench on the first cycle_start tick.
    task automatic test_reset(input logic pal);
        int per;
        int end_at;
        int m2_rise;
        per = pal ? 32 : 24;
        end_at = -1;
        m2_rise = -1;
        region_pal = pal;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(m2 === 1'b0, "R1", "m2 in reset", int'(m2), 0);
        chk(phi2 === 1'b0, "R1", "phi2 in reset", int'(phi2), 0);
        chk(phi1 === 1'b1, "R1", "phi1 in reset", int'(phi1), 1);
        chk(cycle_start === 1'b0 && phi2_start === 1'b0, "R1", "pulses in reset",
            int'({cycle_start, phi2_start}), 0);
        rst = 1'b0;
        for (int t = 1; t <= per + 8 && end_at < 0; t++) begin
            @(negedge clk);
            if (m2 === 1'b1 && m2_rise < 0) m2_rise = t;
            if (cycle_start === 1'b1) end_at = t;
        end
        chk(end_at == per, "R1", "ticks to first cycle_start", end_at, per);
        chk(m2_rise == (pal ? 13 : 9), pal ? "R6" : "R5", "first m2 rise after reset",
            m2_rise, pal ? 13 : 9);
    endtask

    // Time one full cycle from the current cycle_start tick to the next one.
    // sw_at / sw_back: tick at which region_pal is set to sw_val / set back (-1 = never).
    task automatic run_cycle(input logic pal, input int sw_at, input int sw_back,
                             input logic sw_val, input string tag);
        int per, m2h, half;
        int end_at, m2_rise, p2_rise, mid_at, m2_hi, p2_hi, bad_phi1;
        string rp, rm;
        per = pal ? 32 : 24;
        m2h = pal ? 19 : 15;
        half = per / 2;
        rp = pal ? "R3" : "R2";
        rm = pal ? "R6" : "R5";
        end_at = -1; m2_rise = -1; p2_rise = -1; mid_at = -1;
        m2_hi = 0; p2_hi = 0; bad_phi1 = 0;
        for (int t = 1; t <= per + 8 && end_at < 0; t++) begin
            if (t - 1 == sw_at) region_pal = sw_val;
            if (t - 1 == sw_back) region_pal = ~sw_val;
            @(negedge clk);
            if (phi1 === phi2) bad_phi1++;
            if (cycle_start === 1'b1) begin
                end_at = t;
                chk(m2 === 1'b0 && phi2 === 1'b0, "R7", {tag, " m2/phi2 low at boundary"},
                    int'({m2, phi2}), 0);
            end else begin
                if (m2 === 1'b1) m2_hi++;
                if (phi2 === 1'b1) p2_hi++;
            end
            if (m2 === 1'b1 && m2_rise < 0) m2_rise = t;
            if (phi2 === 1'b1 && p2_rise < 0) p2_rise = t;
            if (phi2_start === 1'b1 && mid_at < 0) mid_at = t;
        end
        chk(end_at == per, (sw_at >= 0) ? "R9" : rp, {tag, " cycle length"}, end_at, per);
        chk(m2_rise == per - m2h, rm, {tag, " m2 rise tick"}, m2_rise, per - m2h);
        chk(m2_hi == m2h, rm, {tag, " m2 high ticks"}, m2_hi, m2h);
        chk(p2_hi == half, "R4", {tag, " phi2 high ticks"}, p2_hi, half);
        chk(bad_phi1 == 0, "R4", {tag, " phi1 not complement of phi2"}, bad_phi1, 0);
        chk(m2_rise < p2_rise, "R7", {tag, " m2 rises before phi2"}, m2_rise, p2_rise);
        chk(mid_at == half && p2_rise == half, "R8", {tag, " phi2_start tick"}, mid_at, half);
    endtask

    task automatic test_short_region;
        run_cycle(1'b0, -1, -1, 1'b0, "short#1");
        run_cycle(1'b0, -1, -1, 1'b0, "short#2");
    endtask

    task automatic test_midcycle_switch;
        run_cycle(1'b0, 5, -1, 1'b1, "switch mid-cycle");
        run_cycle(1'b1, -1, -1, 1'b1, "long#1");
        run_cycle(1'b1, -1, -1, 1'b1, "long#2");
    endtask

    task automatic test_withdrawn_pulse;
        run_cycle(1'b1, 3, 7, 1'b0, "withdrawn pulse");
        run_cycle(1'b1, -1, -1, 1'b1, "after withdrawn pulse (R9)");
    endtask

    task automatic test_last_tick_switch;
        run_cycle(1'b1, 31, -1, 1'b0, "switch on last tick");
        run_cycle(1'b0, -1, -1, 1'b0, "after last-tick switch (R9)");
    endtask

    task automatic test_reset_mid_cycle;
        for (int i = 0; i < 14; i++) @(negedge clk);
        chk(m2 === 1'b1, "R5", "m2 high before mid-cycle reset", int'(m2), 1);
        test_reset(1'b1);
        run_cycle(1'b1, -1, -1, 1'b1, "long after reset");
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset(1'b0);
        test_short_region();
        test_midcycle_switch();
        test_withdrawn_pulse();
        test_last_tick_switch();
        test_reset_mid_cycle();
        region_pal = 1'b0;
        test_reset(1'b0);
        test_short_region();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule